// File: doc/BRIEF.md
# Byte-Addressed Synchronous Data Memory

This block is the data store of a small 32-bit processor. It holds 4096 bytes behind one port. The port has a request strobe, a write enable, a 32-bit byte address, 32-bit write data and a 32-bit read word that is registered on the clock.

A word access may start at any byte address, including addresses whose four bytes fall into two aligned words. The bytes are ordered little-endian. The storage is built as four byte-wide banks, one per low address value. Each bank works out its own row from the request address, so a misaligned read or write finishes in a single cycle.

The read word is not always data. It carries a fixed marker word in these cases:
- 0xFA11_1EAF when the cycle had no request.
- 0xFA11_1EAF when the cycle was a write.
- 0xDEAD_BEEF when a read would touch a byte past the end of the array.

The choice is held in a small output state machine. Its four states are:
- `OUT_IDLE`: entered on reset or on a cycle with no request.
- `OUT_STORE`: entered on a request with write enable high.
- `OUT_LOAD`: entered on a read whose four bytes are all inside the array.
- `OUT_FAULT`: entered on a read with any byte outside the array.

Every state can move to every other state on the next edge. The transition is decided only by that cycle's request, write enable and address. Memory contents are never preloaded.

Top module: `byte_dmem`

## Requirements
- R1: When `mem_req` and `mem_we` are both high at a rising edge, byte k of `mem_wdata` (bits 8k+7..8k) is stored at byte address `mem_addr`+k, for k = 0 to 3.
- R2: `mem_rdata` is registered. It changes only at a rising edge, reflecting the request of the cycle just ended, and holds its value until the next edge.
- R3: After an edge where `mem_req` was low, `mem_rdata` is 0xFA11_1EAF.
- R4: After an edge where `mem_req` and `mem_we` were both high, `mem_rdata` is 0xFA11_1EAF.
- R5: A read at address A (request high, write enable low, A at most 4092) returns byte A in bits 7..0, A+1 in 15..8, A+2 in 23..16 and A+3 in 31..24. This holds at any alignment. Example: with 0x7654_3210 written at 0 and 0xFECD_BA98 at 4, a read at 2 returns 0xBA98_7654.
- R6: A read at any address above 4092, so that at least one byte lies past 4095, returns 0xDEAD_BEEF.
- R7: A read never alters stored bytes. Repeated reads of one address with no write between them return the same word.
- R8: A write whose bytes partly pass address 4095 stores its in-range bytes and drops the rest.
- R9: While `rst_n` is low at a rising edge, `mem_rdata` becomes 0xFA11_1EAF. The array contents are not touched by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the output state |
| mem_req | input | 1 | Access request for this cycle |
| mem_we | input | 1 | Write when high, read when low |
| mem_addr | input | 32 | Byte address of the first byte |
| mem_wdata | input | 32 | Write word, lowest byte goes to the lowest address |
| mem_rdata | output | 32 | Registered read word or marker word |

## Verification
The array is first filled by aligned writes, so every later read has a known value. A long random mix then follows. It has idle cycles, writes at every alignment and reads at every alignment, plus a share of addresses far above the array. This mix separates the four output states from one another and shows whether the bank rotation puts each byte in the right lane. Directed cases target the boundaries:
- The worked example from R5.
- Reads at 4092, 4093 and 4095, which split valid data from the fault marker.
- A write at 4094 that is partly dropped.
- Back-to-back reads of one address.
- A mid-cycle look at the output, which shows the value is held between edges.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    typedef enum logic [1:0] {
        OUT_IDLE  = 2'd0,
        OUT_STORE = 2'd1,
        OUT_LOAD  = 2'd2,
        OUT_FAULT = 2'd3
    } out_state_e;

    localparam logic [31:0] QUIET_WORD = 32'hFA11_1EAF;
    localparam logic [31:0] FAULT_WORD = 32'hDEAD_BEEF;

endpackage

// File: rtl/dmem_lane_map.sv
module dmem_lane_map #(
    parameter int ADDR_W    = 32,
    parameter int LANES     = 4,
    parameter int MEM_BYTES = 4096,
    parameter int LANE_W    = 2,
    parameter int ROW_W     = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_W-1:0]  row     [LANES],
    output logic [LANE_W-1:0] src_lane[LANES],
    output logic [LANES-1:0]  lane_ok
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_BYTES);

    always_comb begin
        logic [LANE_W-1:0] offs;
        logic [ADDR_W:0]   byte_addr;
        for (int b = 0; b < LANES; b++) begin
            offs        = LANE_W'(b) - addr[LANE_W-1:0];
            byte_addr   = {1'b0, addr} + (ADDR_W+1)'(offs);
            src_lane[b] = offs;
            lane_ok[b]  = byte_addr < LIMIT;
            row[b]      = byte_addr[LANE_W +: ROW_W];
        end
    end

endmodule

// File: rtl/dmem_byte_bank.sv
module dmem_byte_bank #(
    parameter int ROWS  = 1024,
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [ROW_W-1:0] row,
    input  logic [7:0]       wr_byte,
    output logic [7:0]       rd_byte
);

    logic [7:0] cells [ROWS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[row] <= wr_byte;
        end
        if (rd_en) begin
            rd_byte <= cells[row];
        end
    end

endmodule

// File: rtl/dmem_read_align.sv
module dmem_read_align #(
    parameter int LANES  = 4,
    parameter int LANE_W = 2
) (
    input  logic [7:0]         bank_q[LANES],
    input  logic [LANE_W-1:0]  rot,
    output logic [LANES*8-1:0] word
);

    always_comb begin
        logic [LANE_W-1:0] pick;
        for (int i = 0; i < LANES; i++) begin
            pick           = rot + LANE_W'(i);
            word[i*8 +: 8] = bank_q[pick];
        end
    end

endmodule

// File: rtl/byte_dmem.sv
module byte_dmem
    import dmem_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MEM_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] mem_rdata
);

    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int ROWS   = MEM_BYTES / LANES;
    localparam int ROW_W  = $clog2(ROWS);

    logic [ROW_W-1:0]  row     [LANES];
    logic [LANE_W-1:0] src_lane[LANES];
    logic [LANES-1:0]  lane_ok;
    logic [7:0]        bank_q  [LANES];
    logic [DATA_W-1:0] aligned;
    logic [LANE_W-1:0] rot_q;
    logic              do_write, do_read, whole_ok;
    out_state_e        state_q, state_d;

    dmem_lane_map #(
        .ADDR_W(ADDR_W), .LANES(LANES), .MEM_BYTES(MEM_BYTES),
        .LANE_W(LANE_W), .ROW_W(ROW_W)
    ) i_map (
        .addr(mem_addr), .row(row), .src_lane(src_lane), .lane_ok(lane_ok)
    );

    assign whole_ok = &lane_ok;
    assign do_write = mem_req & mem_we;
    assign do_read  = mem_req & ~mem_we & whole_ok;

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        dmem_byte_bank #(.ROWS(ROWS), .ROW_W(ROW_W)) i_bank (
            .clk    (clk),
            .wr_en  (do_write & lane_ok[b]),
            .rd_en  (do_read),
            .row    (row[b]),
            .wr_byte(mem_wdata[src_lane[b]*8 +: 8]),
            .rd_byte(bank_q[b])
        );
    end

    always_ff @(posedge clk) begin
        if (do_read) begin
            rot_q <= mem_addr[LANE_W-1:0];
        end
    end

    dmem_read_align #(.LANES(LANES), .LANE_W(LANE_W)) i_align (
        .bank_q(bank_q), .rot(rot_q), .word(aligned)
    );

    always_comb begin
        if (!mem_req) begin
            state_d = OUT_IDLE;
        end else if (mem_we) begin
            state_d = OUT_STORE;
        end else if (!whole_ok) begin
            state_d = OUT_FAULT;
        end else begin
            state_d = OUT_LOAD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            OUT_IDLE:  mem_rdata = DATA_W'(QUIET_WORD);
            OUT_STORE: mem_rdata = DATA_W'(QUIET_WORD);
            OUT_FAULT: mem_rdata = DATA_W'(FAULT_WORD);
            OUT_LOAD:  mem_rdata = aligned;
            default:   mem_rdata = DATA_W'(QUIET_WORD);
        endcase
    end

endmodule

// File: rtl/dmem_checker.sv
module dmem_checker
    import dmem_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MEM_BYTES = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_rdata
);

    localparam logic [ADDR_W-1:0] LAST_START = ADDR_W'(MEM_BYTES - DATA_W / 8);

    p_idle_marker_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req) |=> (mem_rdata == DATA_W'(QUIET_WORD)));

    p_write_marker_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (mem_rdata == DATA_W'(QUIET_WORD)));

    p_fault_marker_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_addr > LAST_START) |=> (mem_rdata == DATA_W'(FAULT_WORD)));

    p_reread_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_addr <= LAST_START &&
         $past(mem_req && !mem_we && rst_n) && $stable(mem_addr))
        |=> $stable(mem_rdata));

    p_reset_quiet_r9: assert property (@(posedge clk)
        (!rst_n) |=> (mem_rdata == DATA_W'(QUIET_WORD)));

endmodule

bind byte_dmem dmem_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_BYTES(MEM_BYTES)
) i_dmem_checker (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata)
);

// File: tb/test_byte_dmem.sv
module test_byte_dmem;

    localparam int CLK_PERIOD = 10;
    localparam int NBYTES     = 4096;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    byte_dmem i_byte_dmem (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0]  model [NBYTES];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    int          checks = 0;
    int          fails  = 0;
    bit          finished = 1'b0;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    // driver: applies one access at a falling edge and queues its expected result
    task automatic issue(input bit req, input bit we, input logic [31:0] a,
                         input logic [31:0] d, input string tag);
        logic [31:0] want;
        @(negedge clk);
        mem_req = req; mem_we = we; mem_addr = a; mem_wdata = d;
        if (!req || we) begin
            want = 32'hFA11_1EAF;
        end else if (a > 32'(NBYTES - 4)) begin
            want = 32'hDEAD_BEEF;
        end else begin
            want = {model[a+3], model[a+2], model[a+1], model[a]};
        end
        if (req && we) begin
            for (int k = 0; k < 4; k++) begin
                if ({1'b0, a} + 33'(k) < 33'(NBYTES)) model[a+k] = d[k*8 +: 8];
            end
        end
        exp_q.push_back(want);
        tag_q.push_back(tag);
    endtask

    // monitor: compares each registered result just after the edge that produces it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                check(tag_q.pop_front(), mem_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        rst_n = 1'b0; mem_req = 1'b1; mem_we = 1'b0; mem_addr = 32'd0; mem_wdata = 32'd0;
        repeat (3) @(posedge clk);
        #1 check("R9", mem_rdata, 32'hFA11_1EAF);
        @(negedge clk);
        rst_n = 1'b1; mem_req = 1'b0;

        // R1: fill every byte with aligned writes
        for (int w = 0; w < NBYTES; w += 4) issue(1'b1, 1'b1, 32'(w), $urandom, "R4");

        // R5 worked example across a word seam
        issue(1'b1, 1'b1, 32'd0, 32'h7654_3210, "R1");
        issue(1'b1, 1'b1, 32'd4, 32'hFECD_BA98, "R1");
        issue(1'b1, 1'b0, 32'd2, 32'd0, "R5");
        issue(1'b1, 1'b0, 32'd0, 32'd0, "R5");
        issue(1'b0, 1'b0, 32'd2, 32'd0, "R3");

        // R6 boundaries
        issue(1'b1, 1'b0, 32'd4092, 32'd0, "R5");
        issue(1'b1, 1'b0, 32'd4093, 32'd0, "R6");
        issue(1'b1, 1'b0, 32'd4095, 32'd0, "R6");
        issue(1'b1, 1'b0, 32'hFFFF_FFFF, 32'd0, "R6");

        // R8: partial write at the top edge
        issue(1'b1, 1'b1, 32'd4094, 32'hA1B2_C3D4, "R8");
        issue(1'b1, 1'b0, 32'd4092, 32'd0, "R8");

        // R7: repeated reads give same word
        issue(1'b1, 1'b0, 32'd101, 32'd0, "R7");
        issue(1'b1, 1'b0, 32'd101, 32'd0, "R7");
        issue(1'b1, 1'b0, 32'd101, 32'd0, "R7");

        // R2: value holds through the cycle after the edge
        issue(1'b1, 1'b0, 32'd7, 32'd0, "R2");
        @(posedge clk);
        #1 held = mem_rdata;
        #3 check("R2", mem_rdata, held);

        // random mix of idle, write and read at all alignments
        for (int n = 0; n < 4000; n++) begin
            bit          rq;
            bit          wr;
            logic [31:0] ad;
            string       tg;
            rq = ($urandom % 10) != 0;
            wr = ($urandom % 2) == 1;
            ad = (($urandom % 8) == 0) ? $urandom : 32'($urandom % NBYTES);
            if (!rq)                        tg = "R3";
            else if (wr)                    tg = "R4";
            else if (ad > 32'(NBYTES - 4))  tg = "R6";
            else                            tg = "R5";
            issue(rq, wr, ad, $urandom, tg);
        end

        @(negedge clk);
        mem_req = 1'b0;
        @(posedge clk);
        #2;
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule